// File: doc/BRIEF.md
# Masked Sticky Event Flags with Clear-on-Read Interrupt

This block gathers one-cycle trigger pulses into 32 sticky flags. The flags are arranged as four status words of eight bits each. Each status word has its own eight-bit enable mask. A single active-high interrupt line is raised while any flag and its enable bit are both set.

Software services the interrupt by reading status words through a simple read port. Reading a word returns its flags and clears that word only. Reading just the words whose enable bits are set is therefore enough to drop the interrupt. A trigger that arrives in the same cycle as the read of its word takes priority over the clear, so no event is lost. The enable masks are loaded through a small write port.

Top module: `evt_irq_status`

## Requirements
- R1: A high bit on `trigIn` sets the matching flag at the next clock edge. The flag stays set until its word is read. Flag n lives in word n/8 at bit n%8.
- R2: When `rdEn` is high at an edge, `rdData` takes the flags of word `rdAddr` as they stood before that edge's clear. `rdData` then holds its value until the next read.
- R3: A read clears only the flags of the addressed word. Flags of the other three words keep their value.
- R4: If a trigger for a flag arrives in the same cycle as a read of that flag's word, the flag stays set and reads back as 1 on the following read.
- R5: `irq` is the registered OR over all 32 bits of (flag AND enable). It follows a flag or mask change one cycle later.
- R6: Once asserted, `irq` falls only after a read, or a mask write, has removed every enabled set flag. Reading only the words that hold enabled flags is sufficient. Set flags whose enable bit is 0 do not hold `irq` high.
- R7: A flag whose enable bit is 0 is still set by its trigger and reads back as 1. Masking affects only `irq`.
- R8: When `maskWrEn` is high at an edge, the mask of word `maskWrAddr` is loaded from `maskWrData`. The other masks are unchanged.
- R9: While `rstN` is low, all flags, masks, `rdData` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 32 | One-cycle event pulses, one per flag |
| rdEn | input | 1 | Read strobe for a status word |
| rdAddr | input | 2 | Index of the status word to read |
| rdData | output | 8 | Flags of the last word read, as they were before its clear |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrAddr | input | 2 | Index of the mask word to load |
| maskWrData | input | 8 | New enable bits |
| irq | output | 1 | Interrupt, high while any enabled flag is set |

## Verification
The bound checker tests on every cycle the following properties:
- flags stick after a trigger;
- a read clears only its own word, while a coincident trigger survives;
- read data is the state before the clear;
- the one-cycle lag of `irq`;
- a fall of `irq` only after a read or a mask write;
- mask loads.

Some behaviours can only be shown by the bench's scenarios:
- the reset values;
- that a masked flag still reads back as 1;
- that reading only the enabled words is enough to silence the interrupt;
- that a flag kept by a coincident trigger appears on the next read.

A behavioural model then compares both outputs on every clock during a long random phase.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  parameter int NREG = 4;
  parameter int REGW = 8;
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int NFLAG = NREG * REGW;

  typedef struct packed {
    logic [NREG-1:0] clrHit;
    logic [NREG-1:0] maskLoad;
    logic            rdCapture;
    logic [AW-1:0]   rdIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/irqst_ctrl.sv
module irqst_ctrl
  import irqst_pkg::*;
(
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  input  logic          maskWrEn,
  input  logic [AW-1:0] maskWrAddr,
  output ctlStrobe_t    ctl
);
  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign ctl.clrHit[k]   = rdEn && (rdAddr == AW'(k));
    assign ctl.maskLoad[k] = maskWrEn && (maskWrAddr == AW'(k));
  end
  assign ctl.rdCapture = rdEn;
  assign ctl.rdIdx     = rdAddr;
endmodule

// File: rtl/irqst_datapath.sv
module irqst_datapath
  import irqst_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NFLAG-1:0] trigIn,
  input  logic [REGW-1:0]  maskData,
  input  ctlStrobe_t       ctl,
  output logic [NFLAG-1:0] flagVec,
  output logic [NFLAG-1:0] maskVec,
  output logic [REGW-1:0]  rdData,
  output logic             irq
);
  for (genvar k = 0; k < NREG; k++) begin : g_word
    logic [REGW-1:0] flagQ, maskQ, trigSlice;
    assign trigSlice = trigIn[k*REGW +: REGW];

    // set has priority over the read clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ <= '0;
      else if (ctl.clrHit[k]) flagQ <= trigSlice;
      else flagQ <= flagQ | trigSlice;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskQ <= '0;
      else if (ctl.maskLoad[k]) maskQ <= maskData;
    end

    assign flagVec[k*REGW +: REGW] = flagQ;
    assign maskVec[k*REGW +: REGW] = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctl.rdCapture) rdData <= flagVec[ctl.rdIdx*REGW +: REGW];
      irq <= |(flagVec & maskVec);
    end
  end
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import irqst_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NFLAG-1:0] trigIn,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [REGW-1:0]  rdData,
  input  logic             maskWrEn,
  input  logic [AW-1:0]    maskWrAddr,
  input  logic [REGW-1:0]  maskWrData,
  output logic             irq
);
  ctlStrobe_t       ctl;
  logic [NFLAG-1:0] flagVec;
  logic [NFLAG-1:0] maskVec;

  irqst_ctrl ctrl_i (
    .rdEn(rdEn), .rdAddr(rdAddr), .maskWrEn(maskWrEn),
    .maskWrAddr(maskWrAddr), .ctl(ctl)
  );

  irqst_datapath dp_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .maskData(maskWrData),
    .ctl(ctl), .flagVec(flagVec), .maskVec(maskVec),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/irqst_checker.sv
module irqst_checker
  import irqst_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [NFLAG-1:0] trigIn,
  input logic             rdEn,
  input logic [AW-1:0]    rdAddr,
  input logic [REGW-1:0]  rdData,
  input logic             maskWrEn,
  input logic [AW-1:0]    maskWrAddr,
  input logic [REGW-1:0]  maskWrData,
  input logic             irq,
  input logic [NFLAG-1:0] flagVec,
  input logic [NFLAG-1:0] maskVec
);
  logic [REGW-1:0] selFlags;
  assign selFlags = flagVec[rdAddr*REGW +: REGW];

  AST_TRIG_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (|trigIn) |=> ((flagVec & $past(trigIn)) == $past(trigIn))); // R1

  AST_RDDATA_PRECLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (rdData == $past(selFlags))); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(|(flagVec & maskVec)))); // R5

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(rdEn || maskWrEn, 2)); // R6

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    AST_READ_CLEAR_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && rdAddr == AW'(k)) |=>
        (flagVec[k*REGW +: REGW] == $past(trigIn[k*REGW +: REGW]))); // R4

    AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !(rdEn && rdAddr == AW'(k)) |=>
        (flagVec[k*REGW +: REGW] ==
         ($past(flagVec[k*REGW +: REGW]) | $past(trigIn[k*REGW +: REGW])))); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      (maskWrEn && maskWrAddr == AW'(k)) |=>
        (maskVec[k*REGW +: REGW] == $past(maskWrData))); // R8
  end
endmodule

bind evt_irq_status irqst_checker chk_i (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdData(rdData), .maskWrEn(maskWrEn), .maskWrAddr(maskWrAddr),
  .maskWrData(maskWrData), .irq(irq), .flagVec(flagVec), .maskVec(maskVec)
);

// File: tb/evt_irq_status_tb_top.sv
`timescale 1ns/1ps
module evt_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] trigIn = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        maskWrEn = 1'b0;
  logic [1:0]  maskWrAddr = '0;
  logic [7:0]  maskWrData = '0;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] mFlag[4];
  logic [7:0] mMask[4];
  logic [7:0] mRd;
  logic       mIrq;

  always #2 clk = ~clk;

  evt_irq_status dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .maskWrEn(maskWrEn), .maskWrAddr(maskWrAddr),
    .maskWrData(maskWrData), .irq(irq)
  );

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 4; k++) begin
      mFlag[k] = '0;
      mMask[k] = '0;
    end
    mRd = '0;
    mIrq = 1'b0;
  endtask

  // one clock: model update from the applied inputs, then compare
  task automatic step();
    logic any;
    @(posedge clk);
    any = 1'b0;
    for (int k = 0; k < 4; k++) any |= |(mFlag[k] & mMask[k]);
    mIrq = any;
    if (rdEn) mRd = mFlag[rdAddr];
    for (int k = 0; k < 4; k++) begin
      if (rdEn && rdAddr == 2'(k)) mFlag[k] = trigIn[k*8 +: 8];
      else mFlag[k] = mFlag[k] | trigIn[k*8 +: 8];
      if (maskWrEn && maskWrAddr == 2'(k)) mMask[k] = maskWrData;
    end
    #1;
    checkEq("R2 rdData", 32'(rdData), 32'(mRd));
    checkEq("R5 irq", 32'(irq), 32'(mIrq));
  endtask

  task automatic idle();
    trigIn = '0; rdEn = 0; maskWrEn = 0;
  endtask

  task automatic writeMask(int k, logic [7:0] v);
    idle(); maskWrEn = 1; maskWrAddr = 2'(k); maskWrData = v;
    step(); idle();
  endtask

  task automatic readWord(int k);
    idle(); rdEn = 1; rdAddr = 2'(k);
    step(); idle();
  endtask

  task automatic pulse(logic [31:0] t);
    idle(); trigIn = t;
    step(); idle();
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    checkEq("R9 reset rdData", 32'(rdData), 0);
    checkEq("R9 reset irq", 32'(irq), 0);
    rstN = 1'b1;
    step();

    writeMask(0, 8'hFF);
    writeMask(2, 8'h0F);
    writeMask(3, 8'h80);

    // R7: masked flag in word 1 sets but does not raise irq
    pulse(32'h0000_0100);
    step();
    checkEq("R7 masked irq", 32'(irq), 0);
    readWord(1);
    checkEq("R7 masked flag read", 32'(rdData), 32'h01);

    // R5: one cycle lag from flag to irq
    pulse(32'h0000_0008);
    checkEq("R5 irq lag", 32'(irq), 0);
    step();
    checkEq("R5 irq up", 32'(irq), 1);

    // R6/R3: reading another word leaves irq high
    readWord(2);
    step();
    checkEq("R6 wrong word keeps irq", 32'(irq), 1);
    readWord(0);
    checkEq("R2 pre-clear value", 32'(rdData), 32'h08);
    step();
    checkEq("R6 irq drops after read", 32'(irq), 0);

    // R4: coincident trigger beats clear
    pulse(32'h0000_0001);
    idle(); rdEn = 1; rdAddr = 0; trigIn = 32'h0000_0001;
    step(); idle();
    checkEq("R4 read returns old", 32'(rdData), 32'h01);
    readWord(0);
    checkEq("R4 flag survived", 32'(rdData), 32'h01);

    // R3: reading word 2 leaves word 3
    pulse(32'h8004_0000);
    readWord(2);
    checkEq("R3 word2 read", 32'(rdData), 32'h04);
    readWord(3);
    checkEq("R3 word3 kept", 32'(rdData), 32'h80);

    // R8: mask write of another word leaves irq source; own word disables it
    pulse(32'h0000_0040);
    writeMask(1, 8'hFF);
    step();
    checkEq("R8 other mask", 32'(irq), 1);
    writeMask(0, 8'h00);
    step();
    checkEq("R8 own mask off", 32'(irq), 0);
    writeMask(0, 8'hFF);
    readWord(0);
    checkEq("R1 sticky flag", 32'(rdData), 32'h40);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      trigIn   = $urandom & $urandom & $urandom & $urandom;
      rdEn     = ($urandom % 4) == 0;
      rdAddr   = 2'($urandom);
      maskWrEn = ($urandom % 16) == 0;
      maskWrAddr = 2'($urandom);
      maskWrData = 8'($urandom);
      step();
    end
    idle();
    step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule